// File: doc/BRIEF.md
# Master-Mode Audio Frame Clock Generator

This block produces the serial-audio timing for a converter that owns its clocks. From one fast clock it makes a word clock whose rate equals the sample rate, a bit clock at 64 times that rate, and a strobe one cycle wide at the start of every frame. A serializer loads its next left/right sample pair on that strobe. The division chain has two steps. A prescale step divides by 1.5 for the low master-clock-to-sample ratios (96, 192 or 384) or by 3 for the high ratios (192, 384 or 768), as chosen by the prescale select. A speed step then makes one bit clock period from 4, 2 or 1 prescaled steps, for single, double or quad speed.

A divide-by-1.5 cannot land on edges of the master clock itself. The block therefore runs on a clock at twice the master-clock rate. One prescaled step is then a whole count of 3 block cycles (1.5 master clocks) or 6 block cycles (3 master clocks). All outputs are registered in this clock domain.

When the mode pins select external clocking, all three outputs are held low, because the clocks then come from outside. The dividers restart from the start of a frame after reset and after any change of the mode pins or of the prescale select. The word clock always begins with the left half.

Top module: `audio_clkgen`

## Requirements
- R1: With mode 2'b11 (external clocking), the word clock, the bit clock and the strobe are all 0 in the cycle after each edge at which the mode is sampled.
- R2: One prescaled step is 3 block cycles when pre_div3_i is 0 and 6 block cycles when pre_div3_i is 1. A frame lasts 64 × (steps per bit) × (cycles per step) block cycles.
- R3: Each frame has 64 bit clock periods. The word clock is 0 (left) for the first 32 of them and 1 (right) for the last 32.
- R4: A bit clock period is 4, 2 or 1 prescaled steps for mode 2'b00 (single), 2'b01 (double) and 2'b10 (quad).
- R5: Every bit clock period starts low. At single and double speed the bit clock is high for the second half of the period. At quad speed it is high for the last third of the step (1 of 3 cycles, or 2 of 6).
- R6: The word clock changes only in a cycle where the bit clock is 0, so each word clock edge coincides with a bit clock falling edge or with a restart.
- R7: frame_stb_o is 1 for exactly one cycle per frame: the first cycle of the frame. In that cycle the word clock and the bit clock are both 0.
- R8: While rst_ni is 0, all outputs are 0. The first cycle after the first active edge with rst_ni at 1 is the first cycle of a frame.
- R9: A change of mode_i or of pre_div3_i to a non-external setting makes the next cycle the first cycle of a new frame, whatever the point in the frame when the change came.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, twice the master-clock rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Speed / clocking select: 00 single, 01 double, 10 quad, 11 external |
| pre_div3_i | input | 1 | Prescale select: 0 divides by 1.5, 1 divides by 3 |
| word_clk_o | output | 1 | Word clock, 0 during the left half of the frame |
| bit_clk_o | output | 1 | Bit clock, 64 periods per word clock period |
| frame_stb_o | output | 1 | One-cycle pulse in the first cycle of each frame |

## Verification
A wrong phase or step counter shows up within one prescaled step, at most 6 cycles, as a bit clock edge in the wrong cycle. A wrong limit on the step counter shows up at the end of the first frame, as a frame of the wrong length, a strobe in the wrong place, or a word clock half that is not 32 bits long. A missed restart on a change of setting shows up in the very next cycle, where the strobe is missing. The bench compares all three outputs in every cycle against a model that works from the cycle count since the last restart. It also measures frame length, rising edges and high time directly for all six speed and prescale settings.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_EXT    = 2'b11
    } speed_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       pre;
    } cfg_t;

endpackage

// File: rtl/clkgen_prescale.sv
module clkgen_prescale #(
    parameter int PRE_CYC = 3,
    parameter int PH_W    = $clog2(2 * PRE_CYC)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clear_i,
    input  logic            pre_i,
    output logic [PH_W-1:0] ph_n_o,
    output logic            wrap_o
);
    localparam logic [PH_W-1:0] LAST_LO = PH_W'(PRE_CYC - 1);
    localparam logic [PH_W-1:0] LAST_HI = PH_W'(2 * PRE_CYC - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ps_st_t;

    ps_st_t st_d, st_q;
    logic [PH_W-1:0] last;

    always_comb begin
        last   = pre_i ? LAST_HI : LAST_LO;
        st_d   = st_q;
        wrap_o = 1'b0;
        if (clear_i) begin
            st_d.ph = '0;
        end else if (st_q.ph >= last) begin
            st_d.ph = '0;
            wrap_o  = 1'b1;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        ph_n_o = st_d.ph;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/clkgen_tick_ctr.sv
module clkgen_tick_ctr #(
    parameter int FRAME_BITS = 64,
    parameter int BASE_TPB   = 4,
    parameter int TK_W       = $clog2(FRAME_BITS * BASE_TPB)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clear_i,
    input  logic            adv_i,
    input  logic [1:0]      mode_i,
    output logic [TK_W-1:0] tk_n_o
);
    import clkgen_pkg::*;

    localparam logic [TK_W-1:0] LIM_S = TK_W'(FRAME_BITS * BASE_TPB - 1);
    localparam logic [TK_W-1:0] LIM_D = TK_W'(FRAME_BITS * BASE_TPB / 2 - 1);
    localparam logic [TK_W-1:0] LIM_Q = TK_W'(FRAME_BITS * BASE_TPB / 4 - 1);

    typedef struct packed {
        logic [TK_W-1:0] tk;
    } tk_st_t;

    tk_st_t st_d, st_q;
    logic [TK_W-1:0] lim;

    always_comb begin
        unique case (speed_e'(mode_i))
            SPD_SINGLE: lim = LIM_S;
            SPD_DOUBLE: lim = LIM_D;
            default:    lim = LIM_Q;
        endcase
        st_d = st_q;
        if (clear_i) begin
            st_d.tk = '0;
        end else if (adv_i) begin
            st_d.tk = (st_q.tk >= lim) ? '0 : st_q.tk + 1'b1;
        end
        tk_n_o = st_d.tk;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/clkgen_decode.sv
module clkgen_decode #(
    parameter int FRAME_BITS = 64,
    parameter int BASE_TPB   = 4,
    parameter int PRE_CYC    = 3,
    parameter int PH_W       = $clog2(2 * PRE_CYC),
    parameter int TK_W       = $clog2(FRAME_BITS * BASE_TPB)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PH_W-1:0] ph_n_i,
    input  logic [TK_W-1:0] tk_n_i,
    input  logic [1:0]      mode_i,
    input  logic            pre_i,
    input  logic            ext_i,
    output logic            word_clk_o,
    output logic            bit_clk_o,
    output logic            frame_stb_o
);
    localparam int TPB_LG = $clog2(BASE_TPB);
    localparam int FB_LG  = $clog2(FRAME_BITS);
    // quad speed: high for the last third of one prescaled step
    localparam logic [PH_W-1:0] THR_LO = PH_W'(PRE_CYC - PRE_CYC / 3);
    localparam logic [PH_W-1:0] THR_HI = PH_W'(2 * PRE_CYC - (2 * PRE_CYC) / 3);

    typedef struct packed {
        logic word;
        logic bitc;
        logic stb;
    } out_t;

    out_t out_d, out_q;
    int sh_amt;
    logic [TK_W-1:0] bit_pos;
    logic [TK_W-1:0] half_pos;

    always_comb begin
        sh_amt = TPB_LG - int'(mode_i);
        if (sh_amt < 0) sh_amt = 0;
        bit_pos  = tk_n_i >> sh_amt;
        half_pos = tk_n_i >> ((sh_amt > 0) ? sh_amt - 1 : 0);
        out_d.word = bit_pos[FB_LG-1];
        if (sh_amt > 0) out_d.bitc = half_pos[0];
        else            out_d.bitc = (ph_n_i >= (pre_i ? THR_HI : THR_LO));
        out_d.stb = (tk_n_i == '0) && (ph_n_i == '0);
        if (ext_i) out_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign word_clk_o  = out_q.word;
    assign bit_clk_o   = out_q.bitc;
    assign frame_stb_o = out_q.stb;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
    parameter int FRAME_BITS = 64,
    parameter int BASE_TPB   = 4,
    parameter int PRE_CYC    = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       pre_div3_i,
    output logic       word_clk_o,
    output logic       bit_clk_o,
    output logic       frame_stb_o
);
    import clkgen_pkg::*;

    localparam int PH_W = $clog2(2 * PRE_CYC);
    localparam int TK_W = $clog2(FRAME_BITS * BASE_TPB);

    typedef struct packed {
        cfg_t cfg;
        logic restart;
    } top_st_t;

    top_st_t st_d, st_q;
    cfg_t cfg_now;
    logic is_ext, clear;
    logic [PH_W-1:0] ph_n;
    logic [TK_W-1:0] tk_n;
    logic wrap;

    always_comb begin
        cfg_now.mode = mode_i;
        cfg_now.pre  = pre_div3_i;
        is_ext = (speed_e'(mode_i) == SPD_EXT);
        clear  = st_q.restart || (cfg_now != st_q.cfg) || is_ext;
        st_d.cfg     = cfg_now;
        st_d.restart = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cfg     <= '0;
            st_q.restart <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    clkgen_prescale #(.PRE_CYC(PRE_CYC), .PH_W(PH_W)) pre_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
        .pre_i(pre_div3_i), .ph_n_o(ph_n), .wrap_o(wrap)
    );

    clkgen_tick_ctr #(.FRAME_BITS(FRAME_BITS), .BASE_TPB(BASE_TPB), .TK_W(TK_W)) tick_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear),
        .adv_i(wrap), .mode_i(mode_i), .tk_n_o(tk_n)
    );

    clkgen_decode #(.FRAME_BITS(FRAME_BITS), .BASE_TPB(BASE_TPB), .PRE_CYC(PRE_CYC),
                    .PH_W(PH_W), .TK_W(TK_W)) dec_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ph_n_i(ph_n), .tk_n_i(tk_n),
        .mode_i(mode_i), .pre_i(pre_div3_i), .ext_i(is_ext),
        .word_clk_o(word_clk_o), .bit_clk_o(bit_clk_o), .frame_stb_o(frame_stb_o)
    );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] mode_i,
    input logic       pre_div3_i,
    input logic       word_clk_o,
    input logic       bit_clk_o,
    input logic       frame_stb_o
);
    // R1: external clocking silences all outputs
    a_r1_ext_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i == 2'b11 |=> (!word_clk_o && !bit_clk_o && !frame_stb_o));

    // R6: word clock only moves while the bit clock is low
    a_r6_word_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $changed(word_clk_o) |-> !bit_clk_o);

    // R7: strobe sits in the left half, with the bit clock low
    a_r7_stb_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |-> (!word_clk_o && !bit_clk_o));

    // R7: strobe lasts one cycle
    a_r7_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_stb_o |=> !frame_stb_o);

    // R8: first cycle after reset starts a frame
    a_r8_reset_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(rst_ni) && mode_i != 2'b11) |=> frame_stb_o);

    // R9: a change of setting restarts the frame
    a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && mode_i != 2'b11 &&
         (mode_i != $past(mode_i) || pre_div3_i != $past(pre_div3_i))) |=> frame_stb_o);
endmodule

bind audio_clkgen audio_clkgen_chk chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pre_div3_i(pre_div3_i),
    .word_clk_o(word_clk_o), .bit_clk_o(bit_clk_o), .frame_stb_o(frame_stb_o)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic pre = 1'b0;
    logic word_clk, bit_clk, frame_stb;

    int ntot = 0;
    int nbad = 0;
    int nidx = 0;
    bit pend = 1'b1;
    bit done = 1'b0;
    logic [1:0] cur_m = 2'b00;
    logic cur_p = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_clkgen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pre_div3_i(pre),
        .word_clk_o(word_clk), .bit_clk_o(bit_clk), .frame_stb_o(frame_stb)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d at n=%0d", req, act, expv, nidx);
        end
    endtask

    // {word, bit, strobe} expected at cycle n after a restart
    function automatic logic [2:0] model(int n, logic [1:0] m, logic p);
        int cyc, tpb, steps, ph, t, bi, k;
        logic w, b, s;
        if (m == 2'b11) return 3'b000;
        cyc = p ? 6 : 3;
        tpb = 4 >> m;
        steps = 64 * tpb;
        ph = n % cyc;
        t  = (n / cyc) % steps;
        bi = t / tpb;
        k  = t % tpb;
        w = (bi >= 32);
        b = (tpb > 1) ? (k >= tpb / 2) : (ph >= cyc - cyc / 3);
        s = ((n % (cyc * steps)) == 0);
        return {w, b, s};
    endfunction

    task automatic run_seg(logic [1:0] m, logic p, int ncyc, string tag0);
        bit rs;
        logic [2:0] got, expv;
        rs = pend || (m != cur_m) || (p != cur_p);
        mode = m; pre = p; cur_m = m; cur_p = p; pend = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (rs && i == 0) nidx = 0; else nidx++;
            got  = {word_clk, bit_clk, frame_stb};
            expv = model(nidx, m, p);
            chk(got == expv, (rs && i == 0) ? tag0 :
                ((m == 2'b11) ? "R1" : "R3/R4/R5/R6/R7"), int'(got), int'(expv));
        end
    endtask

    // direct measurement over one whole frame after a fresh restart
    task automatic measure(logic [1:0] m, logic p);
        int cyc, tpb, flen, rises, highs, whigh, stbs, first_w;
        logic prevb;
        run_seg(2'b11, p, 3, "R1");
        mode = m; pre = p; cur_m = m; cur_p = p; pend = 1'b0;
        cyc = p ? 6 : 3;
        tpb = 4 >> m;
        flen = cyc * 64 * tpb;
        rises = 0; highs = 0; whigh = 0; stbs = 0; first_w = -1; prevb = 1'b0;
        for (int i = 0; i <= flen; i++) begin
            @(negedge clk);
            if (i < flen) begin
                if (bit_clk && !prevb) rises++;
                if (bit_clk) highs++;
                if (word_clk) whigh++;
                if (word_clk && first_w < 0) first_w = i;
                if (frame_stb) stbs++;
                prevb = bit_clk;
            end else begin
                chk(frame_stb == 1'b1, "R2 frame length (strobe at end)", int'(frame_stb), 1);
            end
        end
        nidx = flen;
        chk(stbs == 1, "R7 strobes per frame", stbs, 1);
        chk(rises == 64, "R4 bit clock periods per frame", rises, 64);
        chk(highs == ((tpb > 1) ? flen / 2 : 64 * (cyc / 3)), "R5 bit clock high cycles",
            highs, (tpb > 1) ? flen / 2 : 64 * (cyc / 3));
        chk(whigh == flen / 2, "R3 word clock high cycles", whigh, flen / 2);
        chk(first_w == flen / 2, "R3 left half length", first_w, flen / 2);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({word_clk, bit_clk, frame_stb} == 3'b000, "R8 outputs in reset",
            int'({word_clk, bit_clk, frame_stb}), 0);
        rst_n = 1'b1;
        pend = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk({word_clk, bit_clk, frame_stb} == 3'b000, "R8 reset state",
            int'({word_clk, bit_clk, frame_stb}), 0);
        rst_n = 1'b1;
        pend = 1'b1;
        run_seg(2'b00, 1'b0, 800, "R8");

        for (int m = 0; m < 3; m++) begin
            for (int p = 0; p < 2; p++) measure(2'(m), 1'(p));
        end

        run_seg(2'b11, 1'b0, 60, "R1");
        run_seg(2'b00, 1'b1, 500, "R9");
        run_seg(2'b10, 1'b1, 300, "R9");
        run_seg(2'b10, 1'b0, 250, "R9");
        run_seg(2'b01, 1'b0, 130, "R9");
        do_reset();
        run_seg(2'b01, 1'b0, 400, "R8");

        for (int s = 0; s < 40; s++) begin
            run_seg(2'($urandom % 4), 1'($urandom % 2), 1 + int'($urandom % 1200), "R9");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            ntot++;
            nbad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end
endmodule